// File: doc/BRIEF.md
# Negate and No-Op Execute Unit

This unit is the execute slice of a small 8-bit core that handles two instructions: the two's-complement negate of one general register, and the no-operation word. Each cycle it accepts one 16-bit instruction word qualified by a valid strobe. The register index is taken from the word and driven straight out as a read address, so the external register file returns the operand in the same cycle. For a negate, the block forms zero minus the operand and the six arithmetic flags. One clock later it presents the register write, the flag values with per-flag write enables, and a program-counter step pulse. The no-operation word only produces the step pulse. Any other valid word raises an illegal indication and writes nothing.

The instruction input is a valid-only stream and has no back-pressure. The unit has no ready output and takes a word on every cycle in which valid is high, so the fetch stage never has to stall for it. Every result appears exactly one cycle after its word and lasts for one cycle.

Top module: `neg_nop_exec`

## Requirements
- R1: A valid word matching 1001_010x_xxxx_0001 (the five x bits, word bits 8..4, give register index 0..31) causes, on the next cycle, `rf_we`=1, `rf_waddr` equal to that index, and `rf_wdata` equal to (0x100 minus the operand) modulo 256.
- R2: An operand of 0x80 is written back as 0x80 with the overflow flag set.
- R3: Overflow (flag bit 3) is 1 exactly when the written result is 0x80.
- R4: Carry (flag bit 0) is 1 whenever the result is nonzero and 0 only for a result of 0x00.
- R5: Half-carry (flag bit 5) equals result bit 3 OR operand bit 3.
- R6: Negative (bit 2) equals result bit 7, zero (bit 1) is set only for a 0x00 result, and sign (bit 4) equals negative XOR overflow.
- R7: After a negate, `flag_we` is 0x3F. Bits 7 (interrupt enable) and 6 (transfer bit) are never enabled.
- R8: The word 0x0000 with valid produces, next cycle, `pc_step`=1 with `rf_we`=0, `flag_we`=0 and `illegal`=0. A negate also produces `pc_step`=1.
- R9: Any other valid word produces, next cycle, `illegal`=1 with `rf_we`=0, `flag_we`=0 and `pc_step`=0.
- R10: A cycle with valid low produces, next cycle, all strobes (`rf_we`, `flag_we`, `pc_step`, `illegal`) at 0.
- R11: While reset is asserted, all outputs except `rf_raddr` are 0.
- R12: `rf_raddr` equals word bits 8..4 in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction word is present this cycle |
| insn_word | input | 16 | Instruction word |
| rf_raddr | output | 5 | Register read index (combinational) |
| rf_rdata | input | 8 | Operand returned by the register file |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | 5 | Register write index |
| rf_wdata | output | 8 | Register write value |
| flag_we | output | 8 | Per-flag write enables (bit 7 I, 6 T, 5 H, 4 S, 3 V, 2 N, 1 Z, 0 C) |
| flag_val | output | 8 | Flag values in the same bit order |
| pc_step | output | 1 | Advance the program counter by one word |
| illegal | output | 1 | Unrecognised valid word |

## Verification
The assertions assume that `rf_rdata` is a pure function of `rf_raddr` within a cycle, so the operand sampled at the edge belongs to the word sampled at that edge. They also assume that valid is held low during reset. The bench models the register file as an array indexed by the address the unit drives. It changes inputs only on falling edges and keeps valid low while reset is asserted. Because of this, each result it predicts pairs one word with the operand that was actually presented for it.

// File: rtl/negx_pkg.sv
package negx_pkg;
  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_N = 2;
  localparam int FLG_V = 3;
  localparam int FLG_S = 4;
  localparam int FLG_H = 5;
  localparam int FLG_T = 6;
  localparam int FLG_I = 7;
  localparam int NFLAGS = 8;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_NOP  = 2'd1,
    OP_NEG  = 2'd2,
    OP_BAD  = 2'd3
  } op_e;
endpackage

// File: rtl/negx_decode.sv
module negx_decode
  import negx_pkg::*;
#(
  parameter int INSN_W = 16,
  parameter int IDX_W  = 5
) (
  input  logic              valid,
  input  logic [INSN_W-1:0] word,
  output op_e               op,
  output logic [IDX_W-1:0]  idx
);
  localparam int IDX_LO = 4;
  localparam logic [6:0] NEG_HI = 7'b1001010;
  localparam logic [3:0] NEG_LO = 4'b0001;

  logic is_neg, is_nop;

  always_comb begin
    is_neg = (word[INSN_W-1 -: 7] == NEG_HI) && (word[3:0] == NEG_LO);
    is_nop = (word == '0);
    idx    = word[IDX_LO +: IDX_W];
    if (!valid)      op = OP_IDLE;
    else if (is_nop) op = OP_NOP;
    else if (is_neg) op = OP_NEG;
    else             op = OP_BAD;
  end
endmodule

// File: rtl/negx_alu.sv
module negx_alu
  import negx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_BIT = 3
) (
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result,
  output logic [NFLAGS-1:0] flags
);
  localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic v_f, n_f, z_f;

  always_comb begin
    result = '0 - operand;
    z_f    = (result == '0);
    v_f    = (result == MIN_NEG);
    n_f    = result[DATA_W-1];
    flags  = '0;
    flags[FLG_C] = ~z_f;
    flags[FLG_Z] = z_f;
    flags[FLG_N] = n_f;
    flags[FLG_V] = v_f;
    flags[FLG_S] = n_f ^ v_f;
    flags[FLG_H] = result[HALF_BIT] | operand[HALF_BIT];
  end
endmodule

// File: rtl/negx_retire.sv
module negx_retire
  import negx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] result,
  input  logic [NFLAGS-1:0] flags,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic [NFLAGS-1:0] flag_we,
  output logic [NFLAGS-1:0] flag_val,
  output logic              pc_step,
  output logic              illegal
);
  localparam logic [NFLAGS-1:0] NEG_MASK =
    NFLAGS'((1 << FLG_C) | (1 << FLG_Z) | (1 << FLG_N) |
            (1 << FLG_V) | (1 << FLG_S) | (1 << FLG_H));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rf_we    <= 1'b0;
      rf_waddr <= '0;
      rf_wdata <= '0;
      flag_we  <= '0;
      flag_val <= '0;
      pc_step  <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      rf_we    <= (op == OP_NEG);
      rf_waddr <= (op == OP_NEG) ? idx : '0;
      rf_wdata <= (op == OP_NEG) ? result : '0;
      flag_we  <= (op == OP_NEG) ? NEG_MASK : '0;
      flag_val <= (op == OP_NEG) ? (flags & NEG_MASK) : '0;
      pc_step  <= (op == OP_NEG) || (op == OP_NOP);
      illegal  <= (op == OP_BAD);
    end
  end
endmodule

// File: rtl/neg_nop_exec.sv
module neg_nop_exec
  import negx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NREGS    = 32,
  parameter int INSN_W   = 16,
  parameter int HALF_BIT = 3,
  localparam int IDX_W   = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_valid,
  input  logic [INSN_W-1:0] insn_word,
  output logic [IDX_W-1:0]  rf_raddr,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic [7:0]        flag_we,
  output logic [7:0]        flag_val,
  output logic              pc_step,
  output logic              illegal
);
  op_e               dec_op;
  logic [IDX_W-1:0]  dec_idx;
  logic [DATA_W-1:0] alu_res;
  logic [NFLAGS-1:0] alu_flags;

  negx_decode #(.INSN_W(INSN_W), .IDX_W(IDX_W)) u_dec (
    .valid (insn_valid),
    .word  (insn_word),
    .op    (dec_op),
    .idx   (dec_idx)
  );

  assign rf_raddr = dec_idx;

  negx_alu #(.DATA_W(DATA_W), .HALF_BIT(HALF_BIT)) u_alu (
    .operand (rf_rdata),
    .result  (alu_res),
    .flags   (alu_flags)
  );

  negx_retire #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_ret (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (dec_op),
    .idx      (dec_idx),
    .result   (alu_res),
    .flags    (alu_flags),
    .rf_we    (rf_we),
    .rf_waddr (rf_waddr),
    .rf_wdata (rf_wdata),
    .flag_we  (flag_we),
    .flag_val (flag_val),
    .pc_step  (pc_step),
    .illegal  (illegal)
  );
endmodule

// File: rtl/negx_checker.sv
module negx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        insn_valid,
  input logic [15:0] insn_word,
  input logic [7:0]  rf_rdata,
  input logic        rf_we,
  input logic [4:0]  rf_waddr,
  input logic [7:0]  rf_wdata,
  input logic [7:0]  flag_we,
  input logic [7:0]  flag_val,
  input logic        pc_step,
  input logic        illegal
);
  logic neg_seen;
  assign neg_seen = insn_valid && (insn_word[15:9] == 7'b1001010) && (insn_word[3:0] == 4'b0001);

  // R1
  neg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    neg_seen |=> rf_we && rf_waddr == $past(insn_word[8:4]) && rf_wdata == 8'(8'd0 - $past(rf_rdata)));
  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> flag_val[3] == (rf_wdata == 8'h80));
  // R4
  carry_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> flag_val[0] == (rf_wdata != 8'h00));
  // R7
  it_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we[7:6] == 2'b00);
  // R9
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !rf_we && flag_we == 8'h00 && !pc_step);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |=> !rf_we && !illegal && !pc_step && flag_we == 8'h00);
endmodule

bind neg_nop_exec negx_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .insn_valid (insn_valid),
  .insn_word  (insn_word),
  .rf_rdata   (rf_rdata),
  .rf_we      (rf_we),
  .rf_waddr   (rf_waddr),
  .rf_wdata   (rf_wdata),
  .flag_we    (flag_we),
  .flag_val   (flag_val),
  .pc_step    (pc_step),
  .illegal    (illegal)
);

// File: tb/tb_neg_nop_exec.sv
module tb_neg_nop_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic [15:0] insn_word = 16'h0000;
  logic [4:0]  rf_raddr;
  logic [7:0]  rf_rdata;
  logic        rf_we;
  logic [4:0]  rf_waddr;
  logic [7:0]  rf_wdata;
  logic [7:0]  flag_we;
  logic [7:0]  flag_val;
  logic        pc_step;
  logic        illegal;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] regs [32];

  logic       e_we, e_step, e_ill;
  logic [4:0] e_waddr;
  logic [7:0] e_wdata, e_fwe, e_fval;

  always #2.5 clk = ~clk;

  assign rf_rdata = regs[rf_raddr];

  neg_nop_exec dut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .flag_we(flag_we), .flag_val(flag_val),
    .pc_step(pc_step), .illegal(illegal)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference model: one instruction per cycle, results one cycle later.
  always @(posedge clk) begin
    if (!rst_n) begin
      e_we <= 0; e_waddr <= 0; e_wdata <= 0; e_fwe <= 0; e_fval <= 0;
      e_step <= 0; e_ill <= 0;
    end else begin
      automatic int d = regs[insn_word[8:4]];
      automatic int r = (256 - d) % 256;
      automatic bit is_neg = insn_word[15:9] == 7'b1001010 && insn_word[3:0] == 4'b0001;
      automatic bit is_nop = insn_word == 16'h0000;
      automatic bit v = (r == 128);
      automatic bit n = r[7];
      if (e_we) regs[e_waddr] <= e_wdata;
      e_we <= 0; e_waddr <= 0; e_wdata <= 0; e_fwe <= 0; e_fval <= 0;
      e_step <= 0; e_ill <= 0;
      if (insn_valid) begin
        if (is_nop) e_step <= 1;
        else if (is_neg) begin
          e_we <= 1; e_step <= 1; e_waddr <= insn_word[8:4]; e_wdata <= 8'(r);
          e_fwe <= 8'h3F;
          e_fval <= {2'b00, r[3] | d[3], n ^ v, v, n, r == 0, r != 0};
        end else e_ill <= 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      // R11 reset state
      chk(!rf_we && !pc_step && !illegal && flag_we == 0 && flag_val == 0 &&
          rf_wdata == 0 && rf_waddr == 0, "R11", "reset outputs",
          {rf_we, pc_step, illegal, flag_we}, 0);
    end else begin
      chk(rf_we == e_we, "R1/R8/R9/R10", "rf_we", rf_we, e_we);
      if (e_we) begin
        chk(rf_waddr == e_waddr, "R1", "rf_waddr", rf_waddr, e_waddr);
        chk(rf_wdata == e_wdata, "R1", "rf_wdata", rf_wdata, e_wdata);
        if (e_wdata == 8'h80) chk(flag_val[3], "R2", "V at 0x80", flag_val[3], 1);
        chk(flag_val[3] == e_fval[3], "R3", "V", flag_val[3], e_fval[3]);
        chk(flag_val[0] == e_fval[0], "R4", "C", flag_val[0], e_fval[0]);
        chk(flag_val[5] == e_fval[5], "R5", "H", flag_val[5], e_fval[5]);
        chk(flag_val[4:1] == e_fval[4:1], "R6", "S/N/Z", flag_val[4:1], e_fval[4:1]);
      end
      chk(flag_we == e_fwe, "R7", "flag_we", flag_we, e_fwe);
      chk(pc_step == e_step, "R8", "pc_step", pc_step, e_step);
      chk(illegal == e_ill, "R9", "illegal", illegal, e_ill);
    end
  end

  task automatic issue(input bit v, input logic [15:0] w);
    @(negedge clk);
    insn_valid = v;
    insn_word  = w;
    #1;
    // R12 combinational read index
    chk(rf_raddr == w[8:4], "R12", "rf_raddr", rf_raddr, w[8:4]);
  endtask

  function automatic logic [15:0] neg_of(input int r);
    return {7'b1001010, 5'(r), 4'b0001};
  endfunction

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = 8'(i * 37 + 5);
    regs[3] = 8'h80; regs[4] = 8'h00; regs[5] = 8'h7F; regs[6] = 8'h01;
    regs[7] = 8'hFF; regs[8] = 8'h08; regs[9] = 8'hF8;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R2..R6 corner operands
    for (int r = 3; r <= 9; r++) issue(1, neg_of(r));
    // R1 all registers
    for (int r = 0; r < 32; r++) issue(1, neg_of(r));
    // R1 back-to-back on one register
    issue(1, neg_of(17)); issue(1, neg_of(17)); issue(1, neg_of(17));
    // R8 no-op, R10 idle with neg-looking word
    issue(1, 16'h0000); issue(0, neg_of(12)); issue(0, 16'hFFFF); issue(1, 16'h0000);
    // R9 unrecognised words
    issue(1, 16'h0001); issue(1, 16'h9402); issue(1, 16'h9601);
    issue(1, 16'hFFFF); issue(1, 16'h1401); issue(1, 16'h9400);
    // sweep every operand value through one register
    for (int k = 0; k < 256; k++) begin
      regs[20] = 8'(k);
      issue(1, neg_of(20));
      issue(0, 16'h0000);
    end
    issue(0, 16'h0000); issue(0, 16'h0000);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule